// File: doc/BRIEF.md
# Odd/Even Bank Request Splitter

This block sits between one load/store requester and a memory arranged as two banks of 16-byte lines. Lines whose address bit 4 is clear live in bank 0; lines whose bit 4 is set live in bank 1. The block takes a request with a byte address, a byte count from 1 to 16, a load/store flag and store data. It decides which bank or banks the request touches and builds one request per touched bank. Each outgoing request carries a line-aligned address, a per-byte enable mask and store data already moved into its byte lanes.

An access that fits inside one line goes only to the bank that owns that line. An access that runs past the end of its line goes to both banks in the same cycle. The part beyond the line boundary goes to the opposite bank at the following line address. Load data returned by the banks is stitched back together and moved down to byte 0. The requester sees a single completion once every issued part has answered, and that completion carries one combined exception flag. Byte-order normalisation, caching and the memory itself are handled elsewhere.

Top module: `bank_pair_splitter`

## Requirements
- R1: While and after reset, busy, resp_valid and both bank valid bits are low until a request arrives.
- R2: A request is taken when req_valid is high and busy is low. Busy is high from the next cycle until completion. A req_valid seen while busy has no effect on the bank ports and is not taken later.
- R3: One cycle after a request is taken, the bank whose index equals address bit 4 (the home bank) receives a valid pulse. Its address has bits 3:0 cleared and bits 47:4 equal to those of the request.
- R4: When the byte offset (address bits 3:0) plus the length exceeds 16, the other bank receives a valid pulse in the same cycle, addressed at the home line address plus 16 (wrapping at the top of the address space). Otherwise only the home bank is addressed.
- R5: req_len is a 5-bit binary byte count from 1 to 16. With W = ((1<<len)-1)<<offset as a 32-bit value, the home bank mask is W[15:0] and the other bank mask is W[31:16]. Mask bit i enables byte i of that bank's line.
- R6: Store data is moved up by offset bytes into a 32-byte window. The home bank receives window bytes 0..15 and the other bank receives bytes 16..31. bk_store is 1 for a store and 0 for a load.
- R7: For a load, result byte i (for i < len) is byte offset+i of the window {other bank data, home bank data}. Result bytes at or beyond len are zero.
- R8: resp_valid pulses for exactly one cycle, in the cycle after the last issued part is acknowledged. Busy is low in that same cycle. Partial acknowledgement produces no completion.
- R9: bk_exc is sampled together with bk_ack. resp_exc is high with resp_valid if any issued part reported an exception, and the transaction still waits for every part.
- R10: Each issued bank sees exactly one valid cycle per request; bk_valid is low in the cycle after an issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Incoming request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | 48 | Byte address |
| req_len | input | 5 | Byte count, 1..16 |
| req_wdata | input | 128 | Store data, byte 0 in bits 7:0 |
| busy | output | 1 | Transaction in progress |
| resp_valid | output | 1 | Completion pulse |
| resp_exc | output | 1 | Completion carried an exception |
| resp_rdata | output | 128 | Merged load data |
| bk_valid | output | 2 | Per-bank request pulse |
| bk_store | output | 1 | Store flag for the bank requests |
| bk_addr | output | 2x48 | Per-bank line-aligned address |
| bk_mask | output | 2x16 | Per-bank byte enables |
| bk_wdata | output | 2x128 | Per-bank store data in lane position |
| bk_ack | input | 2 | Per-bank completion pulse |
| bk_exc | input | 2 | Per-bank exception, qualified by bk_ack |
| bk_rdata | input | 2x128 | Per-bank line data, qualified by bk_ack |

## Verification
The bench sweeps every offset, every length and both home banks, for stores and for loads. This catches an off-by-one in the crossing test, which would send a full-line access at offset 0 to both banks, or drop the tail byte of an access that ends exactly on the boundary. Loads are checked byte by byte against the window, so swapped bank order or a missing zero-fill above the length shows up at once. Directed cases acknowledge the two halves in different cycles while a second request waits at the input. A design that completed on the first acknowledgement, or that took the waiting request, would raise resp_valid early or issue a stray bank pulse. An address at the very top of memory checks that the next-line address wraps to zero. Exceptions are reported on each bank separately, to check that one bad half still produces one completion with the flag set.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;
  localparam int NBANK = 2;
  typedef enum logic {ST_IDLE = 1'b0, ST_ACTIVE = 1'b1} bsplit_state_e;
endpackage

// File: rtl/bsplit_lane_map.sv
module bsplit_lane_map #(
  parameter int ADDR_W     = 48,
  parameter int LINE_BYTES = 16,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LEN_W  = OFF_W + 1,
  localparam int LINE_W = LINE_BYTES * 8
) (
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [LEN_W-1:0]                  len,
  input  logic [LINE_W-1:0]                 wdata,
  output logic [1:0]                        need,
  output logic [2*LINE_BYTES-1:0]           win_mask,
  output logic [1:0][ADDR_W-1:0]            bank_addr,
  output logic [1:0][LINE_BYTES-1:0]        bank_mask,
  output logic [1:0][LINE_W-1:0]            bank_wdata
);
  logic [2*LINE_BYTES-1:0] len_bits;
  logic [2*LINE_W-1:0]     win_data;
  logic [OFF_W-1:0]        off;
  logic                    hb;
  logic [ADDR_W-1:0]       home_line, next_line;

  always_comb begin
    off = addr[OFF_W-1:0];
    hb  = addr[OFF_W];
    len_bits = '0;
    for (int i = 0; i < LINE_BYTES + 1; i++) begin
      if (i < int'(len)) len_bits[i] = 1'b1;
    end
    win_mask  = len_bits << off;
    win_data  = {{LINE_W{1'b0}}, wdata} << {off, 3'b000};
    home_line = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    next_line = home_line + ADDR_W'(LINE_BYTES);
    need       = '0;
    bank_addr  = '0;
    bank_mask  = '0;
    bank_wdata = '0;
    bank_addr[hb]   = home_line;
    bank_addr[!hb]  = next_line;
    bank_mask[hb]   = win_mask[LINE_BYTES-1:0];
    bank_mask[!hb]  = win_mask[2*LINE_BYTES-1:LINE_BYTES];
    bank_wdata[hb]  = win_data[LINE_W-1:0];
    bank_wdata[!hb] = win_data[2*LINE_W-1:LINE_W];
    need[hb]        = |win_mask[LINE_BYTES-1:0];
    need[!hb]       = |win_mask[2*LINE_BYTES-1:LINE_BYTES];
  end
endmodule

// File: rtl/bsplit_load_merge.sv
module bsplit_load_merge #(
  parameter int LINE_BYTES = 16,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = LINE_BYTES * 8
) (
  input  logic                        home,
  input  logic [OFF_W-1:0]            off,
  input  logic [2*LINE_BYTES-1:0]     win_mask,
  input  logic [1:0][LINE_W-1:0]      bank_rdata,
  output logic [LINE_W-1:0]           rdata
);
  logic [2*LINE_W-1:0] joined, kept, moved;

  always_comb begin
    joined = {bank_rdata[!home], bank_rdata[home]};
    for (int i = 0; i < 2*LINE_BYTES; i++) begin
      kept[i*8 +: 8] = win_mask[i] ? joined[i*8 +: 8] : 8'h00;
    end
    moved = kept >> {off, 3'b000};
    rdata = moved[LINE_W-1:0];
  end
endmodule

// File: rtl/bank_pair_splitter.sv
module bank_pair_splitter #(
  parameter int ADDR_W     = 48,
  parameter int LINE_BYTES = 16,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LEN_W  = OFF_W + 1,
  localparam int LINE_W = LINE_BYTES * 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_store,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [LEN_W-1:0]              req_len,
  input  logic [LINE_W-1:0]             req_wdata,
  output logic                          busy,
  output logic                          resp_valid,
  output logic                          resp_exc,
  output logic [LINE_W-1:0]             resp_rdata,
  output logic [1:0]                    bk_valid,
  output logic                          bk_store,
  output logic [1:0][ADDR_W-1:0]        bk_addr,
  output logic [1:0][LINE_BYTES-1:0]    bk_mask,
  output logic [1:0][LINE_W-1:0]        bk_wdata,
  input  logic [1:0]                    bk_ack,
  input  logic [1:0]                    bk_exc,
  input  logic [1:0][LINE_W-1:0]        bk_rdata
);
  import bsplit_pkg::*;

  bsplit_state_e state_q, state_d;
  logic              issue_q;
  logic [1:0]        got_q, got_d;
  logic              exc_q, exc_d, exc_now;
  logic              resp_valid_q, resp_exc_q;
  logic [ADDR_W-1:0] a_q;
  logic [LEN_W-1:0]  len_q;
  logic              st_q;
  logic [LINE_W-1:0] wd_q;
  logic [1:0][LINE_W-1:0] cap_q, cap_d;
  logic [LINE_W-1:0] resp_rdata_q, merged;
  logic              accept, active, done_all;
  logic [1:0]        need;
  logic [2*LINE_BYTES-1:0] win_mask;

  bsplit_lane_map #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) map_i (
    .addr(a_q), .len(len_q), .wdata(wd_q), .need(need), .win_mask(win_mask),
    .bank_addr(bk_addr), .bank_mask(bk_mask), .bank_wdata(bk_wdata)
  );

  bsplit_load_merge #(.LINE_BYTES(LINE_BYTES)) merge_i (
    .home(a_q[OFF_W]), .off(a_q[OFF_W-1:0]), .win_mask(win_mask),
    .bank_rdata(cap_d), .rdata(merged)
  );

  // next-state logic
  always_comb begin
    active   = (state_q == ST_ACTIVE);
    accept   = req_valid && !active;
    done_all = active && ((need & ~(got_q | bk_ack)) == 2'b00);
    exc_now  = exc_q | (active & |(bk_ack & bk_exc));
    state_d  = state_q;
    if (accept)        state_d = ST_ACTIVE;
    else if (done_all) state_d = ST_IDLE;
    got_d = accept ? 2'b00 : (active ? (got_q | bk_ack) : got_q);
    exc_d = accept ? 1'b0 : exc_now;
    for (int b = 0; b < NBANK; b++) begin
      cap_d[b] = (active && bk_ack[b]) ? bk_rdata[b] : cap_q[b];
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      issue_q      <= 1'b0;
      got_q        <= 2'b00;
      exc_q        <= 1'b0;
      resp_valid_q <= 1'b0;
      resp_exc_q   <= 1'b0;
    end else begin
      state_q      <= state_d;
      issue_q      <= accept;
      got_q        <= got_d;
      exc_q        <= exc_d;
      resp_valid_q <= done_all;
      resp_exc_q   <= done_all & exc_now;
    end
  end

  // data registers, enable-gated, no reset
  always_ff @(posedge clk) begin
    if (accept) begin
      a_q   <= req_addr;
      len_q <= req_len;
      st_q  <= req_store;
      wd_q  <= req_wdata;
    end
    cap_q <= cap_d;
    if (done_all) resp_rdata_q <= merged;
  end

  assign busy       = (state_q == ST_ACTIVE);
  assign resp_valid = resp_valid_q;
  assign resp_exc   = resp_exc_q;
  assign resp_rdata = resp_rdata_q;
  assign bk_store   = st_q;
  assign bk_valid   = issue_q ? need : 2'b00;

  // R10: an issue lasts one cycle
  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_valid != 2'b00) |=> (bk_valid == 2'b00));
  // R8: completion is a single pulse with busy already low
  a_r8_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  a_r8_resp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !busy);
  // R2: busy only starts after a request
  a_r2_busy_from_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
  // R9: exception flag only with a completion
  a_r9_exc_with_resp: assert property (@(posedge clk) disable iff (!rst_n)
    resp_exc |-> resp_valid);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank_chk
    // R3: each bank only sees its own line parity, line aligned
    a_r3_bank_line: assert property (@(posedge clk) disable iff (!rst_n)
      bk_valid[g] |-> (bk_addr[g][OFF_W-1:0] == '0 && bk_addr[g][OFF_W] == 1'(g)));
    // R5: an issued part always enables at least one byte
    a_r5_mask_live: assert property (@(posedge clk) disable iff (!rst_n)
      bk_valid[g] |-> (bk_mask[g] != '0));
  end
endmodule

// File: tb/bank_pair_splitter_tb.sv
module bank_pair_splitter_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_store;
  logic [47:0] req_addr;
  logic [4:0] req_len;
  logic [127:0] req_wdata;
  logic busy, resp_valid, resp_exc;
  logic [127:0] resp_rdata;
  logic [1:0] bk_valid;
  logic bk_store;
  logic [1:0][47:0] bk_addr;
  logic [1:0][15:0] bk_mask;
  logic [1:0][127:0] bk_wdata;
  logic [1:0] bk_ack, bk_exc;
  logic [1:0][127:0] bk_rdata;

  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  bank_pair_splitter dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .busy(busy), .resp_valid(resp_valid), .resp_exc(resp_exc), .resp_rdata(resp_rdata),
    .bk_valid(bk_valid), .bk_store(bk_store), .bk_addr(bk_addr), .bk_mask(bk_mask),
    .bk_wdata(bk_wdata), .bk_ack(bk_ack), .bk_exc(bk_exc), .bk_rdata(bk_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] pat(input int seed);
    logic [127:0] p;
    for (int i = 0; i < 16; i++) p[i*8 +: 8] = 8'(seed + i * 13);
    return p;
  endfunction

  task automatic run_one(input logic [47:0] addr, input int len, input bit store,
                         input logic [127:0] wd, input logic [127:0] rd0, input logic [127:0] rd1,
                         input logic [1:0] excv, input bit stagger);
    logic [3:0] off;
    logic h;
    logic [63:0] m64;
    logic [1:0] en;
    logic [1:0][47:0] ea;
    logic [1:0][15:0] em;
    logic [1:0][127:0] ew;
    logic [255:0] wdw, win;
    logic [127:0] exp_rd, rdh, rdo;
    logic [47:0] line;
    logic exp_exc;
    bit split_acks;
    off  = addr[3:0];
    h    = addr[4];
    m64  = ((64'd1 << len) - 64'd1) << off;
    line = {addr[47:4], 4'h0};
    wdw  = {128'h0, wd} << (int'(off) * 8);
    en = 2'b00; ea = '0; em = '0; ew = '0;
    en[h] = 1'b1;              en[!h] = (m64[31:16] != 16'h0);
    ea[h] = line;              ea[!h] = line + 48'd16;
    em[h] = m64[15:0];         em[!h] = m64[31:16];
    ew[h] = wdw[127:0];        ew[!h] = wdw[255:128];
    rdh = h ? rd1 : rd0;       rdo = h ? rd0 : rd1;
    win = {rdo, rdh};
    exp_rd = '0;
    for (int i = 0; i < 16; i++)
      if (i < len) exp_rd[i*8 +: 8] = win[(int'(off) + i) * 8 +: 8];
    exp_exc = |(excv & en);
    split_acks = stagger && (en == 2'b11);

    @(negedge clk);
    req_valid = 1'b1; req_store = store; req_addr = addr; req_len = 5'(len); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R2 busy after accept", 256'(busy), 256'(1));
    chk(bk_valid == en, "R4 bank valid set", 256'(bk_valid), 256'(en));
    chk(bk_valid[h] == 1'b1, "R3 home bank valid", 256'(bk_valid), 256'(en));
    chk(bk_store == store, "R6 store flag", 256'(bk_store), 256'(store));
    for (int b = 0; b < 2; b++) begin
      if (en[b]) begin
        chk(bk_addr[b] == ea[b], "R3 R4 bank address", 256'(bk_addr[b]), 256'(ea[b]));
        chk(bk_mask[b] == em[b], "R5 bank mask", 256'(bk_mask[b]), 256'(em[b]));
        if (store) chk(bk_wdata[b] == ew[b], "R6 bank store data", 256'(bk_wdata[b]), 256'(ew[b]));
      end
    end
    bk_rdata[0] = rd0; bk_rdata[1] = rd1;
    if (split_acks) begin
      bk_ack = 2'b00; bk_ack[h] = 1'b1;
      bk_exc = 2'b00; bk_exc[h] = excv[h];
      req_valid = 1'b1; req_addr = addr ^ 48'h0000_0F00_0010; req_len = 5'd3;
      @(negedge clk);
      bk_ack = 2'b00; bk_exc = 2'b00; bk_rdata = '0;
      chk(bk_valid == 2'b00, "R2 R10 no issue while busy", 256'(bk_valid), 256'(0));
      chk(resp_valid == 1'b0, "R8 no completion on partial ack", 256'(resp_valid), 256'(0));
      chk(busy == 1'b1, "R8 busy held on partial ack", 256'(busy), 256'(1));
      @(negedge clk);
      bk_rdata[0] = 128'h0; bk_rdata[1] = 128'h0;
      bk_rdata[!h] = rdo;
      bk_ack = 2'b00; bk_ack[!h] = 1'b1;
      bk_exc = 2'b00; bk_exc[!h] = excv[!h];
      req_valid = 1'b0;
    end else begin
      bk_ack = en; bk_exc = excv & en;
    end
    @(negedge clk);
    bk_ack = 2'b00; bk_exc = 2'b00; bk_rdata = '0;
    chk(bk_valid == 2'b00, "R10 valid dropped", 256'(bk_valid), 256'(0));
    chk(resp_valid == 1'b1, "R8 completion pulse", 256'(resp_valid), 256'(1));
    chk(busy == 1'b0, "R8 busy low at completion", 256'(busy), 256'(0));
    chk(resp_exc == exp_exc, "R9 exception flag", 256'(resp_exc), 256'(exp_exc));
    if (!store && !exp_exc) chk(resp_rdata == exp_rd, "R7 merged load data", 256'(resp_rdata), 256'(exp_rd));
    @(negedge clk);
    chk(resp_valid == 1'b0, "R8 completion one cycle", 256'(resp_valid), 256'(0));
    chk(bk_valid == 2'b00 && busy == 1'b0, "R2 waiting request not taken", 256'({busy, bk_valid}), 256'(0));
  endtask

  initial begin
    #(20 * 150000);
    $display("FAIL watchdog expired");
    nerr++;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; req_addr = '0; req_len = 5'd1;
    req_wdata = '0; bk_ack = 2'b00; bk_exc = 2'b00; bk_rdata = '0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && resp_valid == 0 && bk_valid == 0, "R1 reset state", 256'({busy, resp_valid, bk_valid}), 256'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && resp_valid == 0 && bk_valid == 0, "R1 idle after reset", 256'({busy, resp_valid, bk_valid}), 256'(0));

    for (int h = 0; h < 2; h++)
      for (int off = 0; off < 16; off++)
        for (int len = 1; len <= 16; len++) begin
          int k;
          logic [47:0] a;
          k = h * 256 + off * 16 + len;
          a = {43'(k * 1237 + 5), h[0], off[3:0]};
          run_one(a, len, 1'b1, pat(k * 7), pat(0), pat(0), 2'b00, 1'b0);
          run_one(a, len, 1'b0, pat(0), pat(k), pat(k + 101), 2'b00, 1'b0);
        end

    // staggered acknowledgements with a request waiting at the input
    run_one(48'h0000_1234_567B, 12, 1'b0, pat(0), pat(3), pat(77), 2'b00, 1'b1);
    run_one(48'h0000_1234_5669, 16, 1'b1, pat(9), pat(0), pat(0), 2'b00, 1'b1);
    // exceptions on either half, and on a single-bank access
    run_one(48'h0000_0000_0A1E, 8, 1'b0, pat(0), pat(5), pat(6), 2'b01, 1'b1);
    run_one(48'h0000_0000_0A0E, 8, 1'b0, pat(0), pat(5), pat(6), 2'b01, 1'b1);
    run_one(48'h0000_0000_0A02, 4, 1'b1, pat(2), pat(0), pat(0), 2'b01, 1'b0);
    run_one(48'h0000_0000_0A02, 4, 1'b0, pat(0), pat(8), pat(9), 2'b10, 1'b0);
    // exception cleared for the next transaction
    run_one(48'h0000_0000_0A02, 4, 1'b0, pat(0), pat(8), pat(9), 2'b00, 1'b0);
    // next-line address wraps at the top of memory
    run_one(48'hFFFF_FFFF_FFF5, 16, 1'b0, pat(0), pat(40), pat(50), 2'b00, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule